// File: doc/BRIEF.md
# Vertical Sync Regularity Rater

This block rates how steadily vertical sync pulses arrive inside the window that a separate window controller opens, and from that rating picks which window the controller should use next. A single up/down quality count rises when a field brings a pulse inside the window and falls when it does not. Set count values move the block between three modes: a wide search window, a near-norm window and a tight norm window. The count is reloaded on each threshold crossing, so each mode has its own hysteresis.

Misses weigh more in wide search than hits do. In near-norm and norm, a pulse that comes right after one or more misses is still scored as a miss, so a source that alternates good and bad fields cannot hold a tight window. Loss of horizontal lock sends the block straight back to wide search with the count cleared. A force bit holds the block in wide search.

Top module: `sync_norm_rater`

## Requirements
- R1: After reset, mode_o is 0 (wide search), count_o is 0 and norm_o is 0.
- R2: In wide search, a field with a pulse raises count_o by 1, and a field without one lowers it by 2, stopping at 0.
- R3: In wide search, when the count would reach 26 (and force_wide_i is low), the mode becomes 1 (near-norm) and the count is reloaded to 10.
- R4: In near-norm, a field scored as a hit raises the count by 1 and a field scored as a miss lowers it by 1.
- R5: In near-norm, when the count would reach 17, the mode becomes 2 (norm) and the count is reloaded to 10.
- R6: In near-norm, when a miss would bring the count to 0, the mode becomes 0 and the count is reloaded to 12.
- R7: In norm, when a miss would bring the count to 0, the mode becomes 1 and the count is reloaded to 14.
- R8: In near-norm and norm, the first field with a pulse after one or more fields without one is scored as a miss. The field after it is scored on its own merit.
- R9: sync_lost_i high on any clock cycle sets mode 0 and count 0 at the next edge, whether eval_i is high or low, and it takes priority over all other inputs.
- R10: With force_wide_i high, an evaluated field in near-norm or norm sets mode 0 and count 12. In wide search the count then stops at 25 and the mode does not leave wide search.
- R11: In norm, the count saturates at 31.
- R12: norm_o is 1 exactly when mode_o is 2.
- R13: Without eval_i or sync_lost_i, mode_o and count_o hold their values whatever found_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eval_i | input | 1 | One-cycle strobe, once per field, when the window result is valid |
| found_i | input | 1 | Pulse was found inside the window in this field (sampled with eval_i) |
| sync_lost_i | input | 1 | Horizontal sync not locked; clears to wide search |
| force_wide_i | input | 1 | Hold wide search mode |
| mode_o | output | 2 | Window mode: 0 wide, 1 near-norm, 2 norm |
| count_o | output | 5 | Current quality count |
| norm_o | output | 1 | Readable status: block is in norm mode |

## Verification
The bench builds the block with its default parameters: a 5-bit count, a rise at 26 out of wide search and at 17 out of near-norm, and reloads of 10, 12 and 14. With these values a few hundred fields reach every transition: both rises, both falls, the 31 saturation in norm, the 25 ceiling under force, and the miss-then-hit scoring in both tight modes. A reference model in the bench predicts each field's mode and count, and a monitor compares them one cycle after each strobe.

// File: rtl/snr_pkg.sv
package snr_pkg;
  typedef enum logic [1:0] {
    MODE_WIDE = 2'd0,
    MODE_NEAR = 2'd1,
    MODE_NORM = 2'd2
  } snr_mode_e;
endpackage

// File: rtl/snr_hit_filter.sv
// Scores a found pulse as a miss when it follows a miss in near/norm mode.
module snr_hit_filter
  import snr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      eval_i,
  input  logic      found_i,
  input  logic      sync_lost_i,
  input  snr_mode_e mode_i,
  input  snr_mode_e mode_nxt_i,
  output logic      hit_o
);
  logic missed_q, missed_d;

  assign hit_o = found_i && !((mode_i != MODE_WIDE) && missed_q);

  always_comb begin
    missed_d = missed_q;
    if (sync_lost_i) begin
      missed_d = 1'b0;
    end else if (eval_i) begin
      if ((mode_nxt_i != mode_i) || (mode_i == MODE_WIDE)) missed_d = 1'b0;
      else missed_d = !found_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) missed_q <= 1'b0;
    else         missed_q <= missed_d;
  end

  // R8: a miss in a tight mode makes the next found pulse score as a miss
  a_r8_second_chance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !sync_lost_i && !found_i && mode_i != MODE_WIDE && mode_nxt_i == mode_i)
    |=> (mode_i == MODE_WIDE || !hit_o || $past(mode_nxt_i) != mode_i));
endmodule

// File: rtl/snr_step.sv
// Next mode and count for one field.
module snr_step
  import snr_pkg::*;
#(
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned WIDE_RISE  = 26,
  parameter int unsigned NEAR_RISE  = 17,
  parameter int unsigned RISE_LOAD  = 10,
  parameter int unsigned WIDE_LOAD  = 12,
  parameter int unsigned NEAR_LOAD  = 14
) (
  input  snr_mode_e        mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             eval_i,
  input  logic             hit_i,
  input  logic             sync_lost_i,
  input  logic             force_wide_i,
  output snr_mode_e        mode_nxt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam int unsigned UW = CNT_W + 1;
  localparam logic [UW-1:0]    CNT_MAX  = UW'((1 << CNT_W) - 1);
  localparam logic [UW-1:0]    W_RISE   = UW'(WIDE_RISE);
  localparam logic [UW-1:0]    N_RISE   = UW'(NEAR_RISE);
  localparam logic [UW-1:0]    F_CEIL   = UW'(WIDE_RISE - 1);
  localparam logic [CNT_W-1:0] L_RISE   = CNT_W'(RISE_LOAD);
  localparam logic [CNT_W-1:0] L_WIDE   = CNT_W'(WIDE_LOAD);
  localparam logic [CNT_W-1:0] L_NEAR   = CNT_W'(NEAR_LOAD);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO      = CNT_W'(2);

  logic [UW-1:0] up;
  assign up = {1'b0, cnt_i} + UW'(1);

  always_comb begin
    mode_nxt_o = mode_i;
    cnt_nxt_o  = cnt_i;
    if (sync_lost_i) begin
      mode_nxt_o = MODE_WIDE;
      cnt_nxt_o  = '0;
    end else if (eval_i) begin
      if (force_wide_i && mode_i != MODE_WIDE) begin
        mode_nxt_o = MODE_WIDE;
        cnt_nxt_o  = L_WIDE;
      end else begin
        unique case (mode_i)
          MODE_WIDE: begin
            if (hit_i) begin
              if (force_wide_i && up > F_CEIL) begin
                cnt_nxt_o = F_CEIL[CNT_W-1:0];
              end else if (up >= W_RISE) begin
                mode_nxt_o = MODE_NEAR;
                cnt_nxt_o  = L_RISE;
              end else begin
                cnt_nxt_o = up[CNT_W-1:0];
              end
            end else begin
              cnt_nxt_o = (cnt_i < TWO) ? '0 : cnt_i - TWO;
            end
          end
          MODE_NEAR: begin
            if (hit_i) begin
              if (up >= N_RISE) begin
                mode_nxt_o = MODE_NORM;
                cnt_nxt_o  = L_RISE;
              end else begin
                cnt_nxt_o = up[CNT_W-1:0];
              end
            end else if (cnt_i <= ONE) begin
              mode_nxt_o = MODE_WIDE;
              cnt_nxt_o  = L_WIDE;
            end else begin
              cnt_nxt_o = cnt_i - ONE;
            end
          end
          MODE_NORM: begin
            if (hit_i) begin
              cnt_nxt_o = (up > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : up[CNT_W-1:0];
            end else if (cnt_i <= ONE) begin
              mode_nxt_o = MODE_NEAR;
              cnt_nxt_o  = L_NEAR;
            end else begin
              cnt_nxt_o = cnt_i - ONE;
            end
          end
          default: begin
            mode_nxt_o = MODE_WIDE;
            cnt_nxt_o  = '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sync_norm_rater.sv
module sync_norm_rater
  import snr_pkg::*;
#(
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned WIDE_RISE = 26,
  parameter int unsigned NEAR_RISE = 17,
  parameter int unsigned RISE_LOAD = 10,
  parameter int unsigned WIDE_LOAD = 12,
  parameter int unsigned NEAR_LOAD = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eval_i,
  input  logic             found_i,
  input  logic             sync_lost_i,
  input  logic             force_wide_i,
  output logic [1:0]       mode_o,
  output logic [CNT_W-1:0] count_o,
  output logic             norm_o
);
  localparam logic [CNT_W-1:0] CEIL_F = CNT_W'(WIDE_RISE - 1);
  localparam logic [CNT_W-1:0] L_RISE = CNT_W'(RISE_LOAD);
  localparam logic [CNT_W-1:0] L_WIDE = CNT_W'(WIDE_LOAD);
  localparam logic [CNT_W-1:0] L_NEAR = CNT_W'(NEAR_LOAD);

  snr_mode_e        mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit;

  snr_hit_filter u_filter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .eval_i      (eval_i),
    .found_i     (found_i),
    .sync_lost_i (sync_lost_i),
    .mode_i      (mode_q),
    .mode_nxt_i  (mode_d),
    .hit_o       (hit)
  );

  snr_step #(
    .CNT_W     (CNT_W),
    .WIDE_RISE (WIDE_RISE),
    .NEAR_RISE (NEAR_RISE),
    .RISE_LOAD (RISE_LOAD),
    .WIDE_LOAD (WIDE_LOAD),
    .NEAR_LOAD (NEAR_LOAD)
  ) u_step (
    .mode_i       (mode_q),
    .cnt_i        (cnt_q),
    .eval_i       (eval_i),
    .hit_i        (hit),
    .sync_lost_i  (sync_lost_i),
    .force_wide_i (force_wide_i),
    .mode_nxt_o   (mode_d),
    .cnt_nxt_o    (cnt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_WIDE;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode_o  = mode_q;
  assign count_o = cnt_q;
  assign norm_o  = (mode_q == MODE_NORM);

  a_r9_lost_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_lost_i |=> (mode_q == MODE_WIDE && cnt_q == '0));

  a_r13_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eval_i && !sync_lost_i) |=> ($stable(cnt_q) && $stable(mode_q)));

  a_r3_wide_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_WIDE) |-> (cnt_q <= CEIL_F));

  a_r2_wide_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && found_i && !sync_lost_i && mode_q == MODE_WIDE && cnt_q < CEIL_F)
    |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  a_r5_norm_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(norm_o) |-> (cnt_q == L_RISE));

  a_r6_near_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !sync_lost_i && !found_i && mode_q == MODE_NEAR && cnt_q == CNT_W'(1))
    |=> (mode_q == MODE_WIDE && cnt_q == L_WIDE));

  a_r7_norm_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !sync_lost_i && !force_wide_i && !found_i && mode_q == MODE_NORM
     && cnt_q == CNT_W'(1))
    |=> (mode_q == MODE_NEAR && cnt_q == L_NEAR));

  a_r10_force_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && force_wide_i) |=> (mode_q == MODE_WIDE));
endmodule

// File: tb/sync_norm_rater_tb_top.sv
module sync_norm_rater_tb_top;
  typedef struct {
    int    mode;
    int    cnt;
    string tag;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       eval_i = 1'b0;
  logic       found_i = 1'b0;
  logic       sync_lost_i = 1'b0;
  logic       force_wide_i = 1'b0;
  logic [1:0] mode_o;
  logic [4:0] count_o;
  logic       norm_o;

  int   n_checks = 0;
  int   n_errors = 0;
  exp_t sb_q[$];
  int   m_mode = 0, m_cnt = 0;
  bit   m_flag = 1'b0;

  always #2 clk_i = ~clk_i;

  sync_norm_rater dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .eval_i(eval_i), .found_i(found_i),
    .sync_lost_i(sync_lost_i), .force_wide_i(force_wide_i),
    .mode_o(mode_o), .count_o(count_o), .norm_o(norm_o)
  );

  task automatic compare(int em, int ec, string tag);
    n_checks++;
    if (int'(mode_o) != em || int'(count_o) != ec || norm_o != (em == 2)) begin
      n_errors++;
      $display("FAIL %s: mode=%0d count=%0d norm=%0d expected mode=%0d count=%0d norm=%0d",
               tag, mode_o, count_o, norm_o, em, ec, (em == 2));
    end
  endtask

  // Reference model from the requirements
  task automatic model(bit f, bit l, bit ev);
    int  pm;
    bit  hit;
    if (l) begin m_mode = 0; m_cnt = 0; m_flag = 0; return; end
    if (!ev) return;
    pm = m_mode;
    if (force_wide_i && m_mode != 0) begin
      m_mode = 0; m_cnt = 12;
    end else begin
      hit = f && !(m_mode != 0 && m_flag);
      case (m_mode)
        0: if (hit) begin
             m_cnt++;
             if (force_wide_i && m_cnt > 25) m_cnt = 25;
             else if (m_cnt == 26) begin m_mode = 1; m_cnt = 10; end
           end else m_cnt = (m_cnt < 2) ? 0 : m_cnt - 2;
        1: if (hit) begin
             m_cnt++;
             if (m_cnt == 17) begin m_mode = 2; m_cnt = 10; end
           end else begin
             m_cnt--;
             if (m_cnt == 0) begin m_mode = 0; m_cnt = 12; end
           end
        default: if (hit) begin
             if (m_cnt < 31) m_cnt++;
           end else begin
             m_cnt--;
             if (m_cnt == 0) begin m_mode = 1; m_cnt = 14; end
           end
      endcase
    end
    m_flag = (m_mode != pm || m_mode == 0) ? 1'b0 : !f;
  endtask

  task automatic field(bit f, string tag);
    exp_t e;
    @(negedge clk_i);
    found_i = f; eval_i = 1'b1;
    model(f, 1'b0, 1'b1);
    e.mode = m_mode; e.cnt = m_cnt; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk_i);
    eval_i = 1'b0;
  endtask

  task automatic lose_lock(bit with_eval, string tag);
    exp_t e;
    @(negedge clk_i);
    found_i = 1'b1; sync_lost_i = 1'b1; eval_i = with_eval;
    model(1'b1, 1'b1, with_eval);
    e.mode = m_mode; e.cnt = m_cnt; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk_i);
    sync_lost_i = 1'b0; eval_i = 1'b0;
  endtask

  task automatic fields(int n, bit f, string tag);
    for (int i = 0; i < n; i++) field(f, tag);
  endtask

  // Monitor: one result per strobe, compared at the next falling edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk_i);
      if (rst_ni && (eval_i || sync_lost_i)) begin
        @(negedge clk_i);
        if (sb_q.size() == 0) begin
          n_checks++; n_errors++;
          $display("FAIL scoreboard: result with no expected item");
        end else begin
          e = sb_q.pop_front();
          compare(e.mode, e.cnt, e.tag);
        end
      end
    end
  end

  initial begin
    #200000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    compare(0, 0, "R1 reset state");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare(0, 0, "R1 after release");

    fields(3, 1'b1, "R2 wide up");
    field(1'b0, "R2 wide down by 2");
    field(1'b0, "R2 wide floor at 0");
    fields(25, 1'b1, "R2 wide climb");
    field(1'b1, "R3 wide to near reload 10");

    field(1'b0, "R4 near miss");
    field(1'b1, "R8 near hit after miss scored miss");
    field(1'b1, "R4 near hit");
    fields(7, 1'b1, "R4 near climb");
    field(1'b1, "R5 near to norm reload 10");
    compare(2, 10, "R12 norm status");

    fields(25, 1'b1, "R11 norm saturate 31");
    field(1'b0, "R4 norm miss");
    field(1'b1, "R8 norm hit after miss scored miss");
    field(1'b1, "R8 norm hit counts again");
    fields(29, 1'b0, "R7 norm decay");
    field(1'b0, "R7 norm to near reload 14");
    fields(13, 1'b0, "R6 near decay");
    field(1'b0, "R6 near to wide reload 12");

    // idle cycles with found high: nothing moves
    found_i = 1'b1;
    repeat (6) @(negedge clk_i);
    compare(0, 12, "R13 idle hold");

    force_wide_i = 1'b1;
    fields(16, 1'b1, "R10 forced wide ceiling 25");
    force_wide_i = 1'b0;
    field(1'b1, "R3 release force rises to near");
    force_wide_i = 1'b1;
    field(1'b1, "R10 force from near to wide 12");
    force_wide_i = 1'b0;

    fields(4, 1'b1, "R2 wide up before lock loss");
    lose_lock(1'b0, "R9 lock loss without strobe");
    fields(26, 1'b1, "R3 climb again");
    fields(2, 1'b1, "R4 near up");
    lose_lock(1'b1, "R9 lock loss beats strobe");
    field(1'b1, "R2 wide restart after loss");

    repeat (4) @(negedge clk_i);
    if (sb_q.size() != 0) begin
      n_checks++; n_errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule